// File: doc/BRIEF.md
# Request-Paced Single-Channel DMA Engine

This block moves bytes from a source address to a destination address without CPU help. It has one channel. Software sets it up through a small register write port. It loads a 20-bit source address, a 20-bit destination address, a byte count, a mode word and a control word. The mode word gives each side its own addressing style: memory with increment, memory with decrement, memory with a fixed address, or I/O space, which drives only the low 16 address bits. Every byte takes two bus cycles. The first is a read strobe at the source address, and the second is a write strobe at the destination address that carries the byte just read.

A request signal paces the transfers. The request comes from one of three places: an external pin, a serial port's transmit-empty flag or a serial port's receive-full flag. It can be edge-sensed, which gives one byte per rising edge, or level-sensed, which moves bytes back to back while the request stays high. The external pin is honoured only when certain upper bits of the I/O-side address are zero. When the count is used up, the channel disables itself. It can also raise a terminal-count interrupt.

The bus side uses a strobe/acknowledge handshake. A read or write strobe, together with its address, I/O flag and write data, stays asserted and unchanged until `bus_ack` is sampled high. The slave applies back-pressure by holding `bus_ack` low. Read data is taken in the cycle where `bus_rd` and `bus_ack` are both high.

Top module: `dma_engine`

## Requirements
- R1: A register write (`reg_wr` high) stores `reg_wdata` into the register chosen by `reg_sel`: 0 selects the source address, 1 the destination address, 2 the byte count (low CNT_W bits), 3 the mode word, and 4 the control word. In the control word, bit 0 is the enable, bit 1 is the enable write-protect and bit 2 is the interrupt enable.
- R2: Mode word bits [1:0] set the source mode and bits [3:2] set the destination mode. The codes are 0 = memory increment, 1 = memory decrement, 2 = memory fixed and 3 = I/O. In I/O mode the address stays fixed, `bus_addr` carries only the low 16 bits with the upper bits zero, and `bus_io` is high.
- R3: Each byte is a read strobe at the current source address, followed by a write strobe at the current destination address that carries the byte read. A strobe and its address stay unchanged until `bus_ack` is high, and the two strobes are never high together.
- R4: After exactly the loaded number of bytes, the enable clears itself and `busy` falls. A loaded count of 0 means 2^CNT_W bytes.
- R5: A control write changes the enable only if bit 1 of that same write is 0. Otherwise the enable keeps its value.
- R6: At terminal count, `irq` goes high if the interrupt enable is set. It stays high until a control write with bit 1 low, or a control write that clears the interrupt enable.
- R7: Mode bits [6:5] select the pacing source: 0 = external pin, 1 = transmit-empty flag, 2 = receive-full flag. In the flag modes the pin has no effect.
- R8: In pin mode the request is honoured only when address bits 16, 17 and 19 are all zero, and bit 18 is ignored. The bits checked are those of the source address if the source is in I/O mode, and of the destination address otherwise.
- R9: Mode bit 4 high selects edge sensing: each rising edge of the request allows exactly one byte, however long the request stays high. With bit 4 low, bytes continue back to back while the request is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | AW | Register write data |
| dreq | input | 1 | External transfer request pin |
| tx_empty | input | 1 | Serial transmit-empty flag |
| rx_full | input | 1 | Serial receive-full flag |
| bus_addr | output | AW | Bus address |
| bus_io | output | 1 | High when the current cycle targets I/O space |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data |
| bus_ack | input | 1 | Slave acknowledge (back-pressure when low) |
| busy | output | 1 | Channel enabled or a byte in flight |
| irq | output | 1 | Terminal-count interrupt |

## Verification
The hardest case to reach is the count-of-zero wrap: 2^CNT_W bytes at the default width would take far too long. The bench therefore builds the engine with an 8-bit count, so a loaded zero finishes in 256 transfers and is checked in full. The second hard case is the gating of the pin by address bits. The bench arms the channel with a blocked address and confirms that nothing moves. It then rewrites only the address register while the channel stays enabled and confirms that the transfer starts. The sweep runs every pairing of source and destination modes against a randomly stalling acknowledge.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [1:0] {
    AM_INC = 2'd0,
    AM_DEC = 2'd1,
    AM_FIX = 2'd2,
    AM_IO  = 2'd3
  } amode_t;

  typedef enum logic [1:0] {
    PACE_PIN  = 2'd0,
    PACE_TX   = 2'd1,
    PACE_RX   = 2'd2,
    PACE_NONE = 2'd3
  } pace_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } state_t;

  localparam logic [2:0] REG_SRC  = 3'd0;
  localparam logic [2:0] REG_DST  = 3'd1;
  localparam logic [2:0] REG_CNT  = 3'd2;
  localparam logic [2:0] REG_MODE = 3'd3;
  localparam logic [2:0] REG_CTRL = 3'd4;

  localparam int CTRL_EN = 0;
  localparam int CTRL_WP = 1;
  localparam int CTRL_IE = 2;

endpackage

// File: rtl/dma_addr_unit.sv
module dma_addr_unit
  import dma_pkg::*;
#(
  parameter int AW  = 20,
  parameter int IOW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  amode_t        mode,
  input  logic          step,
  output logic [AW-1:0] addr_q,
  output logic [AW-1:0] eff_addr
);

  localparam int HIW = AW - IOW;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (load) begin
      addr_q <= load_val;
    end else if (step) begin
      case (mode)
        AM_INC:  addr_q <= addr_q + AW'(1);
        AM_DEC:  addr_q <= addr_q - AW'(1);
        default: addr_q <= addr_q;
      endcase
    end
  end

  always_comb begin
    if (mode == AM_IO) eff_addr = {{HIW{1'b0}}, addr_q[IOW-1:0]};
    else               eff_addr = addr_q;
  end

endmodule

// File: rtl/dma_req_pacer.sv
module dma_req_pacer
  import dma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  pace_t      pace,
  input  logic       edge_mode,
  input  logic       armed,
  input  logic       take,
  input  logic       dreq_pin,
  input  logic       tx_empty,
  input  logic       rx_full,
  input  logic [2:0] gate_bits,
  output logic       grant
);

  logic raw;
  logic raw_q;
  logic pending_q;
  logic rise;

  always_comb begin
    case (pace)
      PACE_PIN: raw = dreq_pin && (gate_bits == 3'b000);
      PACE_TX:  raw = tx_empty;
      PACE_RX:  raw = rx_full;
      default:  raw = 1'b0;
    endcase
  end

  assign rise = raw && !raw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q     <= 1'b0;
      pending_q <= 1'b0;
    end else begin
      raw_q <= raw;
      if (!armed)    pending_q <= 1'b0;
      else if (rise) pending_q <= 1'b1;
      else if (take) pending_q <= 1'b0;
    end
  end

  assign grant = armed && (edge_mode ? pending_q : raw);

endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int AW    = 20,
  parameter int IOW   = 16,
  parameter int CNT_W = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_sel,
  input  logic [AW-1:0] reg_wdata,
  input  logic          dreq,
  input  logic          tx_empty,
  input  logic          rx_full,
  output logic [AW-1:0] bus_addr,
  output logic          bus_io,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ack,
  output logic          busy,
  output logic          irq
);

  localparam int CW   = CNT_W + 1;
  localparam int GB_A = 16;
  localparam int GB_B = 17;
  localparam int GB_C = 19;

  state_t          state_q;
  logic            enable_q, ie_q, tc_q;
  logic [6:0]      mode_q;
  logic [CW-1:0]   cnt_q;
  logic [DW-1:0]   data_q;

  logic wr_cnt, wr_mode, wr_ctrl, ctrl_ok;
  logic take, byte_done, last_byte, grant;
  logic [CNT_W-1:0] cnt_load;

  amode_t          side_mode [2];
  logic            side_load [2];
  logic [AW-1:0]   side_addr [2];
  logic [AW-1:0]   side_eff  [2];
  logic [AW-1:0]   gate_addr;

  assign wr_cnt  = reg_wr && (reg_sel == REG_CNT);
  assign wr_mode = reg_wr && (reg_sel == REG_MODE);
  assign wr_ctrl = reg_wr && (reg_sel == REG_CTRL);
  assign ctrl_ok = wr_ctrl && !reg_wdata[CTRL_WP];

  assign side_mode[0] = amode_t'(mode_q[1:0]);
  assign side_mode[1] = amode_t'(mode_q[3:2]);
  assign side_load[0] = reg_wr && (reg_sel == REG_SRC);
  assign side_load[1] = reg_wr && (reg_sel == REG_DST);

  assign take      = (state_q == ST_IDLE) && enable_q && grant;
  assign byte_done = (state_q == ST_WR) && bus_ack;
  assign last_byte = (cnt_q == CW'(1));
  assign cnt_load  = reg_wdata[CNT_W-1:0];

  for (genvar s = 0; s < 2; s++) begin : g_side
    dma_addr_unit #(.AW(AW), .IOW(IOW)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (side_load[s]),
      .load_val (reg_wdata),
      .mode     (side_mode[s]),
      .step     (byte_done),
      .addr_q   (side_addr[s]),
      .eff_addr (side_eff[s])
    );
  end

  assign gate_addr = (side_mode[0] == AM_IO) ? side_addr[0] : side_addr[1];

  dma_req_pacer u_pacer (
    .clk       (clk),
    .rst_n     (rst_n),
    .pace      (pace_t'(mode_q[6:5])),
    .edge_mode (mode_q[4]),
    .armed     (enable_q),
    .take      (take),
    .dreq_pin  (dreq),
    .tx_empty  (tx_empty),
    .rx_full   (rx_full),
    .gate_bits ({gate_addr[GB_C], gate_addr[GB_B], gate_addr[GB_A]}),
    .grant     (grant)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_mode) mode_q <= reg_wdata[6:0];
      if (wr_cnt)         cnt_q <= {(cnt_load == '0), cnt_load};
      else if (byte_done) cnt_q <= cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= 1'b0;
      ie_q     <= 1'b0;
      tc_q     <= 1'b0;
    end else begin
      if (ctrl_ok)                       enable_q <= reg_wdata[CTRL_EN];
      else if (byte_done && last_byte)   enable_q <= 1'b0;
      if (wr_ctrl)                       ie_q <= reg_wdata[CTRL_IE];
      if (ctrl_ok || (wr_ctrl && !reg_wdata[CTRL_IE])) tc_q <= 1'b0;
      else if (byte_done && last_byte)   tc_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      data_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (take) state_q <= ST_RD;
        ST_RD: if (bus_ack) begin
          data_q  <= bus_rdata;
          state_q <= ST_WR;
        end
        ST_WR: if (bus_ack) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign bus_rd    = (state_q == ST_RD);
  assign bus_wr    = (state_q == ST_WR);
  assign bus_addr  = bus_wr ? side_eff[1] : side_eff[0];
  assign bus_io    = bus_wr ? (side_mode[1] == AM_IO) : (side_mode[0] == AM_IO);
  assign bus_wdata = data_q;
  assign busy      = enable_q || (state_q != ST_IDLE);
  assign irq       = tc_q && ie_q;

endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk #(
  parameter int AW  = 20,
  parameter int IOW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctrl_wr,
  input logic          ctrl_wp,
  input logic [AW-1:0] bus_addr,
  input logic          bus_io,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic          bus_ack,
  input logic          busy,
  input logic          irq
);

  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  a_r3_hold_read: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && !bus_ack |=> bus_rd && $stable(bus_addr));

  a_r3_hold_write: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !bus_ack |=> bus_wr && $stable(bus_addr));

  a_r3_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_wr) |-> $past(bus_rd && bus_ack));

  a_r2_io_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) && bus_io |-> bus_addr[AW-1:IOW] == '0);

  a_r5_protected_enable: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && ctrl_wp && !busy |=> !busy);

  a_r6_irq_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !busy);

endmodule

bind dma_engine dma_engine_chk #(.AW(AW), .IOW(IOW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ctrl_wr  (reg_wr && (reg_sel == dma_pkg::REG_CTRL)),
  .ctrl_wp  (reg_wdata[dma_pkg::CTRL_WP]),
  .bus_addr (bus_addr),
  .bus_io   (bus_io),
  .bus_rd   (bus_rd),
  .bus_wr   (bus_wr),
  .bus_ack  (bus_ack),
  .busy     (busy),
  .irq      (irq)
);

// File: tb/test_dma_engine.sv
`timescale 1ns/1ps
module test_dma_engine;

  localparam int AW = 20;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_sel = '0;
  logic [AW-1:0] reg_wdata = '0;
  logic dreq = 1'b0, tx_empty = 1'b0, rx_full = 1'b0;
  logic [AW-1:0] bus_addr;
  logic bus_io, bus_rd, bus_wr, bus_ack, busy, irq;
  logic [7:0] bus_wdata, bus_rdata;
  logic [7:0] lfsr = 8'h01;
  logic stall_on = 1'b0;

  int checks = 0, errors = 0, nwr = 0;
  logic [AW-1:0] log_addr [512];
  logic [7:0]    log_data [512];
  logic          log_io   [512];
  bit finished = 0;

  always #10 clk = ~clk;

  dma_engine #(.CNT_W(CNT_W)) i_dma_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .dreq(dreq), .tx_empty(tx_empty), .rx_full(rx_full),
    .bus_addr(bus_addr), .bus_io(bus_io), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .busy(busy), .irq(irq));

  function automatic logic [7:0] mem_val(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  assign bus_rdata = mem_val(bus_addr);
  assign bus_ack   = !stall_on || lfsr[0];

  always @(posedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};

  always @(negedge clk) begin
    if (bus_wr && bus_ack) begin
      if (nwr < 512) begin
        log_addr[nwr] = bus_addr;
        log_data[nwr] = bus_wdata;
        log_io[nwr]   = bus_io;
      end
      nwr = nwr + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] sel, input logic [AW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wait_done(input int lim);
    int n = 0;
    while (busy && n < lim) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [AW-1:0] exp_addr(input int m, input logic [AW-1:0] base, input int k);
    case (m)
      0: return base + AW'(k);
      1: return base - AW'(k);
      2: return base;
      default: return {4'h0, base[15:0]};
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] sbase, dbase, ea;
    sbase = 20'h40210;
    dbase = 20'h00480;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    chk(!busy && !irq && !bus_rd && !bus_wr, "R1 reset", {busy, irq, bus_rd, bus_wr}, 0);

    // Sweep all mode pairs, level sensed, pin paced: R2 R3 R4 R6 R9
    dreq = 1'b1;
    for (int sm = 0; sm < 4; sm++) begin
      for (int dm = 0; dm < 4; dm++) begin
        for (int n = 1; n <= 3; n++) begin
          stall_on = n[0];
          nwr = 0;
          wreg(3'd0, sbase);
          wreg(3'd1, dbase);
          wreg(3'd2, AW'(n));
          wreg(3'd3, AW'(sm | (dm << 2)));
          wreg(3'd4, 20'h5);
          wait_done(400);
          chk(nwr == n, "R4 byte count", nwr, n);
          for (int k = 0; k < n; k++) begin
            ea = exp_addr(dm, dbase, k);
            chk(log_addr[k] == ea, "R2 dst address", log_addr[k], ea);
            chk(log_io[k] == (dm == 3), "R2 io flag", log_io[k], dm == 3);
            chk(log_data[k] == mem_val(exp_addr(sm, sbase, k)), "R3 data",
                log_data[k], mem_val(exp_addr(sm, sbase, k)));
          end
          chk(irq == 1'b1, "R6 irq at terminal", irq, 1);
          wreg(3'd4, 20'h2);
          chk(irq == 1'b0, "R6 irq cleared by ie=0", irq, 0);
        end
      end
    end
    stall_on = 1'b0;

    // R5 protected enable write
    nwr = 0;
    wreg(3'd0, sbase); wreg(3'd1, dbase); wreg(3'd2, 20'd2); wreg(3'd3, 20'h0);
    wreg(3'd4, 20'h3);
    idle(20);
    chk(nwr == 0 && !busy, "R5 protected write ignored", nwr, 0);
    wreg(3'd4, 20'h1);
    wait_done(100);
    chk(nwr == 2, "R5 unprotected write starts", nwr, 2);
    chk(irq == 1'b0, "R6 no irq when disabled", irq, 0);

    // R4 zero count means 2^CNT_W
    nwr = 0;
    wreg(3'd2, 20'd0); wreg(3'd4, 20'h1);
    wait_done(2000);
    chk(nwr == (1 << CNT_W), "R4 zero count wraps", nwr, 1 << CNT_W);

    // R8 pin gating on destination address bits
    for (int b = 0; b < 3; b++) begin
      int bit_pos;
      bit_pos = (b == 0) ? 16 : (b == 1) ? 17 : 19;
      nwr = 0;
      wreg(3'd1, 20'h00480 | (20'h1 << bit_pos));
      wreg(3'd2, 20'd1); wreg(3'd3, 20'h0); wreg(3'd4, 20'h1);
      idle(20);
      chk(nwr == 0, "R8 gated by upper bit", nwr, 0);
      wreg(3'd1, 20'h40480);
      wait_done(100);
      chk(nwr == 1 && log_addr[0] == 20'h40480, "R8 bit 18 ignored", log_addr[0], 20'h40480);
    end
    // R8 gating uses source address when source is I/O
    nwr = 0;
    wreg(3'd0, 20'h80210); wreg(3'd1, 20'h10480);
    wreg(3'd3, 20'h3); wreg(3'd2, 20'd1); wreg(3'd4, 20'h1);
    idle(20);
    chk(nwr == 0, "R8 io source gated", nwr, 0);
    wreg(3'd0, 20'h00210);
    wait_done(100);
    chk(nwr == 1, "R8 io source side checked", nwr, 1);

    // R7 serial pacing, pin ignored
    wreg(3'd0, sbase); wreg(3'd1, dbase);
    nwr = 0;
    dreq = 1'b1; tx_empty = 1'b0; rx_full = 1'b1;
    wreg(3'd3, 20'h20); wreg(3'd2, 20'd2); wreg(3'd4, 20'h1);
    idle(20);
    chk(nwr == 0, "R7 pin ignored in tx mode", nwr, 0);
    tx_empty = 1'b1;
    wait_done(100);
    chk(nwr == 2, "R7 tx flag paces", nwr, 2);
    nwr = 0;
    tx_empty = 1'b1; rx_full = 1'b0;
    wreg(3'd3, 20'h40); wreg(3'd2, 20'd2); wreg(3'd4, 20'h1);
    idle(20);
    chk(nwr == 0, "R7 rx mode waits for flag", nwr, 0);
    rx_full = 1'b1;
    wait_done(100);
    chk(nwr == 2, "R7 rx flag paces", nwr, 2);
    tx_empty = 1'b0; rx_full = 1'b0;

    // R9 edge sensing
    nwr = 0; dreq = 1'b0;
    wreg(3'd3, 20'h10); wreg(3'd2, 20'd3); wreg(3'd4, 20'h5);
    idle(15);
    chk(nwr == 0, "R9 no edge no byte", nwr, 0);
    dreq = 1'b1; idle(2); dreq = 1'b0; idle(15);
    chk(nwr == 1, "R9 one byte per edge", nwr, 1);
    dreq = 1'b1; idle(30); dreq = 1'b0; idle(5);
    chk(nwr == 2, "R9 long request one byte", nwr, 2);
    dreq = 1'b1; idle(2); dreq = 1'b0; idle(15);
    chk(nwr == 3 && !busy, "R9 third edge completes", nwr, 3);
    chk(irq == 1'b1, "R6 irq after edge run", irq, 1);
    wreg(3'd4, 20'h4);
    chk(irq == 1'b0, "R6 irq cleared by enable write", irq, 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule